// File: doc/BRIEF.md
# Flash Word Packer

The block takes a byte-granular write request (start byte address, byte count) together with a stream of payload bytes. It turns them into a series of word-program requests for a flash array that can only be programmed one whole aligned 32-bit word at a time. Lanes of a word that the request does not cover are set to 0xFF, so programming leaves those flash bytes as they were. Lane 0 of every word holds the lowest byte address (little-endian packing).

A transfer begins with a one-cycle start pulse while the block is idle. Bytes are taken over a valid/ready stream. Each finished word is presented on the program port, and the port holds it until the flash side returns a done pulse with a pass/fail flag. The block counts only the payload bytes of words that programmed successfully. It ends every accepted start with a one-cycle done pulse and a result code.

Top module: `flash_word_packer`

## Requirements
- R1: After reset, busy, doneValid, byteReady and pgmValid are 0 and bytesWritten is 0.
- R2: Every program request has an address with its two low bits at 0. Requests go out in ascending order, 4 bytes apart, starting at the start address rounded down to a multiple of 4.
- R3: In the first word, lanes below the start offset (startAddr modulo 4) hold 0xFF. Lane i, in bits 8i+7..8i, holds the payload byte for address word base + i. If the payload ends inside this word, the lanes after it hold 0xFF.
- R4: Words between the first and the last carry four consecutive payload bytes, lowest address in lane 0. Every payload byte is taken from the stream exactly once.
- R5: A final partial word carries the remaining bytes in its low lanes and 0xFF in the lanes above them.
- R6: If startAddr + startLen is greater than DEV_BYTES, the block ends with doneCode 1. It issues no request, takes no byte and reports a count of 0.
- R7: A zero startLen ends with doneCode 0, issues no request and reports a count of 0.
- R8: A program response with pgmErr set ends the transfer with doneCode 2. No further request is issued and no further byte is taken.
- R9: bytesWritten is cleared by an accepted start. It rises only on a successful program response, and only by the payload bytes of that word. A full successful transfer with doneCode 0 reports startLen.
- R10: byteReady is 0 in every cycle in which pgmValid is 1.
- R11: Once pgmValid is raised, it stays at 1 with pgmAddr and pgmData unchanged until the cycle in which pgmDone is 1.
- R12: A start pulse that arrives while busy is 1 has no effect on the transfer in progress.
- R13: Each accepted start gives exactly one doneValid pulse lasting one cycle. The block is idle (busy 0) in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start pulse, accepted only while idle |
| startAddr | input | ADDR_W | Byte address of the first payload byte |
| startLen | input | LEN_W | Number of payload bytes |
| busy | output | 1 | A transfer is in progress (includes the done cycle) |
| doneValid | output | 1 | One-cycle end-of-transfer pulse |
| doneCode | output | 2 | Result: 0 ok, 1 out of range, 2 program error |
| byteValid | input | 1 | Payload byte present |
| byteData | input | 8 | Payload byte |
| byteReady | output | 1 | Block takes the byte this cycle |
| pgmValid | output | 1 | Word-program request pending |
| pgmAddr | output | ADDR_W | Word-aligned byte address of the request |
| pgmData | output | 32 | Word to program, lane 0 in bits 7..0 |
| pgmDone | input | 1 | Flash response pulse for the pending request |
| pgmErr | input | 1 | Response reports a failed program |
| bytesWritten | output | LEN_W | Payload bytes in words that programmed successfully |

## Verification
The packer is run with aligned and unaligned starts of short length. These show whether head padding, tail padding and a head word that is also the tail word each come out right. Transfers that span several words separate the handling of full middle words from the handling of partial edges. Lengths that run past the end of the device, or land exactly on it, show where the range check sits. Injected program failures on the first word and on later words show that the count stops at the last good word and that no request follows the failure. Slow byte streams and slow responses shift the timing, so a word can be neither issued early nor changed while it is pending.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

  typedef enum logic [1:0] {
    DONE_OK    = 2'd0,
    DONE_RANGE = 2'd1,
    DONE_IOERR = 2'd2
  } doneCode_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic clearCount;  // accepted start: zero the success counter
    logic load;        // accepted start that will move data
    logic take;        // one byte accepted from the stream
    logic commit;      // successful response: credit pending bytes
    logic advance;     // move to the next aligned word
  } strobes_t;

endpackage

// File: rtl/wpk_datapath.sv
module wpk_datapath
  import wpk_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LEN_W      = 13,
  parameter int WORD_BYTES = 4,
  parameter int DEV_BYTES  = 4096
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobes_t                stb,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic [LEN_W-1:0]        startLen,
  input  logic [7:0]              byteData,
  output logic [ADDR_W-1:0]       pgmAddr,
  output logic [8*WORD_BYTES-1:0] pgmData,
  output logic [LEN_W-1:0]        bytesWritten,
  output logic                    lastLane,
  output logic                    lastByte,
  output logic                    remZero,
  output logic                    lenZero,
  output logic                    rangeBad
);

  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int SUM_W  = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

  logic [ADDR_W-1:0] wordAddr;
  logic [LANE_W-1:0] lane;
  logic [LEN_W-1:0]  remaining;
  logic [LANE_W:0]   pending;
  logic [LEN_W-1:0]  count;
  logic [7:0]        wordData [WORD_BYTES];

  logic [ADDR_W-1:0] alignedStart;
  logic [SUM_W-1:0]  endAddr;

  assign alignedStart = {startAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign endAddr      = SUM_W'(startAddr) + SUM_W'(startLen);
  assign rangeBad     = endAddr > SUM_W'(DEV_BYTES);
  assign lenZero      = (startLen == '0);

  assign lastLane = (lane == LANE_W'(WORD_BYTES - 1));
  assign lastByte = (remaining == LEN_W'(1));
  assign remZero  = (remaining == '0);

  // Word position, lane pointer, byte budget
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr  <= '0;
      lane      <= '0;
      remaining <= '0;
      pending   <= '0;
    end else if (stb.load) begin
      wordAddr  <= alignedStart;
      lane      <= startAddr[LANE_W-1:0];
      remaining <= startLen;
      pending   <= '0;
    end else if (stb.advance) begin
      wordAddr  <= wordAddr + ADDR_W'(WORD_BYTES);
      lane      <= '0;
      pending   <= '0;
    end else if (stb.take) begin
      lane      <= lane + LANE_W'(1);
      remaining <= remaining - LEN_W'(1);
      pending   <= pending + (LANE_W + 1)'(1);
    end
  end

  // Lane storage: every lane starts as erased filler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORD_BYTES; i++) wordData[i] <= 8'hFF;
    end else if (stb.load || stb.advance) begin
      for (int i = 0; i < WORD_BYTES; i++) wordData[i] <= 8'hFF;
    end else if (stb.take) begin
      for (int i = 0; i < WORD_BYTES; i++)
        if (lane == LANE_W'(i)) wordData[i] <= byteData;
    end
  end

  // Success counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (stb.clearCount) count <= '0;
    else if (stb.commit)     count <= count + LEN_W'(pending);
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign pgmData[8*g +: 8] = wordData[g];
  end

  assign pgmAddr      = wordAddr;
  assign bytesWritten = count;

endmodule

// File: rtl/wpk_control.sv
module wpk_control
  import wpk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  input  logic      byteValid,
  input  logic      pgmDone,
  input  logic      pgmErr,
  input  logic      lastLane,
  input  logic      lastByte,
  input  logic      remZero,
  input  logic      lenZero,
  input  logic      rangeBad,
  output strobes_t  stb,
  output logic      busy,
  output logic      byteReady,
  output logic      pgmValid,
  output logic      doneValid,
  output doneCode_t doneCode
);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_REQ, ST_FIN} state_t;

  state_t    state, stateNext;
  doneCode_t codeReg, codeNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    codeNext  = codeReg;
    byteReady = 1'b0;
    pgmValid  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startValid) begin
          stb.clearCount = 1'b1;
          if (lenZero) begin
            codeNext  = DONE_OK;
            stateNext = ST_FIN;
          end else if (rangeBad) begin
            codeNext  = DONE_RANGE;
            stateNext = ST_FIN;
          end else begin
            stb.load  = 1'b1;
            stateNext = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        byteReady = 1'b1;
        if (byteValid) begin
          stb.take = 1'b1;
          if (lastLane || lastByte) stateNext = ST_REQ;
        end
      end
      ST_REQ: begin
        pgmValid = 1'b1;
        if (pgmDone) begin
          if (pgmErr) begin
            codeNext  = DONE_IOERR;
            stateNext = ST_FIN;
          end else begin
            stb.commit = 1'b1;
            if (remZero) begin
              codeNext  = DONE_OK;
              stateNext = ST_FIN;
            end else begin
              stb.advance = 1'b1;
              stateNext   = ST_FILL;
            end
          end
        end
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      codeReg <= DONE_OK;
    end else begin
      state   <= stateNext;
      codeReg <= codeNext;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign doneValid = (state == ST_FIN);
  assign doneCode  = codeReg;

endmodule

// File: rtl/flash_word_packer.sv
module flash_word_packer
  import wpk_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LEN_W      = 13,
  parameter int WORD_BYTES = 4,
  parameter int DEV_BYTES  = 4096
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startValid,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic [LEN_W-1:0]        startLen,
  output logic                    busy,
  output logic                    doneValid,
  output logic [1:0]              doneCode,
  input  logic                    byteValid,
  input  logic [7:0]              byteData,
  output logic                    byteReady,
  output logic                    pgmValid,
  output logic [ADDR_W-1:0]       pgmAddr,
  output logic [8*WORD_BYTES-1:0] pgmData,
  input  logic                    pgmDone,
  input  logic                    pgmErr,
  output logic [LEN_W-1:0]        bytesWritten
);

  strobes_t  stb;
  doneCode_t codeInt;
  logic      lastLane, lastByte, remZero, lenZero, rangeBad;

  wpk_control ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .byteValid  (byteValid),
    .pgmDone    (pgmDone),
    .pgmErr     (pgmErr),
    .lastLane   (lastLane),
    .lastByte   (lastByte),
    .remZero    (remZero),
    .lenZero    (lenZero),
    .rangeBad   (rangeBad),
    .stb        (stb),
    .busy       (busy),
    .byteReady  (byteReady),
    .pgmValid   (pgmValid),
    .doneValid  (doneValid),
    .doneCode   (codeInt)
  );

  wpk_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .WORD_BYTES (WORD_BYTES),
    .DEV_BYTES  (DEV_BYTES)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .startAddr    (startAddr),
    .startLen     (startLen),
    .byteData     (byteData),
    .pgmAddr      (pgmAddr),
    .pgmData      (pgmData),
    .bytesWritten (bytesWritten),
    .lastLane     (lastLane),
    .lastByte     (lastByte),
    .remZero      (remZero),
    .lenZero      (lenZero),
    .rangeBad     (rangeBad)
  );

  assign doneCode = codeInt;

endmodule

// File: rtl/wpk_checker.sv
module wpk_checker #(
  parameter int ADDR_W     = 12,
  parameter int LEN_W      = 13,
  parameter int WORD_BYTES = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    busy,
  input logic                    doneValid,
  input logic                    byteReady,
  input logic                    pgmValid,
  input logic [ADDR_W-1:0]       pgmAddr,
  input logic [8*WORD_BYTES-1:0] pgmData,
  input logic                    pgmDone,
  input logic                    pgmErr,
  input logic [LEN_W-1:0]        bytesWritten
);

  localparam int LANE_W = $clog2(WORD_BYTES);

  // R10
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmValid |-> !byteReady);

  // R11
  req_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pgmValid && !pgmDone) |=> (pgmValid && $stable(pgmAddr) && $stable(pgmData)));

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    pgmValid |-> (pgmAddr[LANE_W-1:0] == '0));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(pgmValid && pgmDone && !pgmErr)) |=> $stable(bytesWritten));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && !busy));

endmodule

bind flash_word_packer wpk_checker #(
  .ADDR_W     (ADDR_W),
  .LEN_W      (LEN_W),
  .WORD_BYTES (WORD_BYTES)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .busy         (busy),
  .doneValid    (doneValid),
  .byteReady    (byteReady),
  .pgmValid     (pgmValid),
  .pgmAddr      (pgmAddr),
  .pgmData      (pgmData),
  .pgmDone      (pgmDone),
  .pgmErr       (pgmErr),
  .bytesWritten (bytesWritten)
);

// File: tb/flash_word_packer_tb.sv
`timescale 1ns/1ps
module flash_word_packer_tb_top;

  localparam int ADDR_W    = 12;
  localparam int LEN_W     = 13;
  localparam int DEV_BYTES = 4096;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startValid = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [LEN_W-1:0]  startLen = '0;
  logic              busy, doneValid, byteReady, pgmValid;
  logic [1:0]        doneCode;
  logic              byteValid = 1'b0;
  logic [7:0]        byteData = '0;
  logic [ADDR_W-1:0] pgmAddr;
  logic [31:0]       pgmData;
  logic              pgmDone = 1'b0;
  logic              pgmErr = 1'b0;
  logic [LEN_W-1:0]  bytesWritten;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  flash_word_packer #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_BYTES(4), .DEV_BYTES(DEV_BYTES)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .startLen(startLen), .busy(busy), .doneValid(doneValid), .doneCode(doneCode),
    .byteValid(byteValid), .byteData(byteData), .byteReady(byteReady),
    .pgmValid(pgmValid), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .pgmDone(pgmDone), .pgmErr(pgmErr), .bytesWritten(bytesWritten)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Byte source
  byte unsigned streamQ[$];
  int  streamIdx = 0;
  bit  armed = 0;

  always @(negedge clk) begin
    if (armed) streamIdx++;
    if (streamIdx < streamQ.size() && ($urandom % 4) != 0) begin
      byteValid = 1'b1;
      byteData  = streamQ[streamIdx];
    end else begin
      byteValid = 1'b0;
    end
    #1 armed = byteValid && byteReady;
  end

  // Flash responder and port monitor
  int unsigned reqAddrQ[$];
  int unsigned reqDataQ[$];
  bit  inFlight = 0;
  int  lat = 0;
  int  reqNum = 0;
  int  failAt = -1;
  int  overlapErr = 0;
  int  stableErr = 0;
  logic [ADDR_W-1:0] heldAddr;
  logic [31:0]       heldData;

  always @(negedge clk) begin
    pgmDone = 1'b0;
    pgmErr  = 1'b0;
    if (pgmValid && byteReady) overlapErr++;
    if (inFlight && (!pgmValid || pgmAddr != heldAddr || pgmData != heldData)) stableErr++;
    if (pgmValid && !inFlight) begin
      reqAddrQ.push_back(32'(pgmAddr));
      reqDataQ.push_back(pgmData);
      heldAddr = pgmAddr;
      heldData = pgmData;
      inFlight = 1;
      lat = int'($urandom % 4);
    end
    if (inFlight) begin
      if (lat == 0) begin
        pgmDone  = 1'b1;
        pgmErr   = (reqNum == failAt);
        reqNum++;
        inFlight = 0;
      end else begin
        lat--;
      end
    end
  end

  task automatic runXfer(input int addr, input int len, input int failIdx, input bit poke);
    int base, nWords, expCode, expReqs, expCount, expTaken, cyc;
    int unsigned expWord;
    string tagW;
    streamQ.delete();
    for (int i = 0; i < len && i < 64; i++) streamQ.push_back(8'($urandom));
    if (len > 64) for (int i = 64; i < len; i++) streamQ.push_back(8'($urandom));
    reqAddrQ.delete();
    reqDataQ.delete();
    reqNum = 0;
    failAt = failIdx;
    overlapErr = 0;
    stableErr = 0;
    @(negedge clk);
    streamIdx = 0;
    startAddr = ADDR_W'(addr);
    startLen  = LEN_W'(len);
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    cyc = 0;
    while (!doneValid && cyc < 3000) begin
      if (poke && cyc == 3 && busy) begin
        startAddr = '0;
        startLen  = '0;
        startValid = 1'b1;
      end
      @(negedge clk);
      startValid = 1'b0;
      cyc++;
    end
    chk(cyc < 3000, "R13", "done pulse seen", cyc, 0);

    // Expected values
    base   = addr & ~3;
    nWords = ((addr & 3) + len + 3) / 4;
    if (len == 0)                       begin expCode = 0; nWords = 0; end
    else if (addr + len > DEV_BYTES)    begin expCode = 1; nWords = 0; end
    else if (failIdx >= 0 && failIdx < nWords) expCode = 2;
    else                                expCode = 0;
    expReqs  = (expCode == 2) ? failIdx + 1 : nWords;
    expCount = 0;
    expTaken = 0;
    for (int w = 0; w < expReqs; w++) begin
      int pay = 0;
      for (int i = 0; i < 4; i++) begin
        int ba = base + 4 * w + i;
        if (ba >= addr && ba < addr + len) pay++;
      end
      expTaken += pay;
      if (!(expCode == 2 && w == failIdx)) expCount += pay;
    end

    tagW = (expCode == 1) ? "R6" : (len == 0) ? "R7" : (expCode == 2) ? "R8" : poke ? "R12" : "R4";
    chk(doneCode == 2'(expCode), tagW, "doneCode", doneCode, expCode);
    chk(bytesWritten == LEN_W'(expCount), (expCode == 0 && len > 0) ? "R9" : tagW,
        "bytesWritten", bytesWritten, expCount);
    chk(reqAddrQ.size() == expReqs, (expCode == 2) ? "R8" : "R2", "request count",
        reqAddrQ.size(), expReqs);
    chk(streamIdx == expTaken, tagW, "bytes taken", streamIdx, expTaken);
    for (int w = 0; w < expReqs && w < reqAddrQ.size(); w++) begin
      expWord = 32'hFFFF_FFFF;
      for (int i = 0; i < 4; i++) begin
        int ba = base + 4 * w + i;
        if (ba >= addr && ba < addr + len) expWord[8*i +: 8] = streamQ[ba - addr];
      end
      chk(reqAddrQ[w] == 32'(base + 4 * w), "R2", "request address", reqAddrQ[w], base + 4 * w);
      if (w == 0)               tagW = "R3";
      else if (w == nWords - 1) tagW = "R5";
      else                      tagW = "R4";
      chk(reqDataQ[w] == expWord, tagW, "request data", reqDataQ[w], expWord);
    end
    chk(overlapErr == 0, "R10", "ready during request", overlapErr, 0);
    chk(stableErr == 0, "R11", "request changed while pending", stableErr, 0);
    @(negedge clk);
    chk(!doneValid && !busy, "R13", "idle after done", {doneValid, busy}, 0);
    streamQ.delete();
    failAt = -1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(!busy && !doneValid && !byteReady && !pgmValid, "R1", "control outputs after reset",
        {busy, doneValid, byteReady, pgmValid}, 0);
    chk(bytesWritten == '0, "R1", "count after reset", bytesWritten, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runXfer(100, 0, -1, 0);     // R7 zero length
    runXfer(4090, 10, -1, 0);   // R6 past end
    runXfer(4092, 4, -1, 0);    // exact fit at the top
    runXfer(4093, 4, -1, 0);    // one byte over: R6
    runXfer(16, 8, -1, 0);      // aligned, full words only
    runXfer(1, 2, -1, 0);       // R3 padded on both sides
    runXfer(3, 1, -1, 0);       // R3 last lane only
    runXfer(2, 9, -1, 0);       // R3 head, R4 middle, R5 tail
    runXfer(40, 5, -1, 0);      // R5 one-byte tail
    runXfer(7, 12, 0, 0);       // R8 fail on first word
    runXfer(8, 20, 2, 0);       // R8 fail in the middle
    runXfer(12, 30, -1, 1);     // R12 start while busy

    for (int t = 0; t < 60; t++) begin
      int a, l, f;
      a = int'($urandom % DEV_BYTES);
      l = int'($urandom % 24);
      if ($urandom % 8 == 0) l = DEV_BYTES - a + 1 + int'($urandom % 4);
      f = ($urandom % 5 == 0) ? int'($urandom % 4) : -1;
      runXfer(a, l, f, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule